// File: doc/BRIEF.md
# Glitch-free system clock selector

This block builds a gated system clock out of three free-running inputs: a primary master clock pin, an alternate master clock pin and the output of an on-chip frequency loop. The choice is made in two cascaded steps. The first step picks one of the two master clocks, and a polarity stage may then invert it. The second step chooses between that master clock and the loop output. A pre-divider that divides by one or by two comes after the second step. A final gate lets software turn the system clock on or off without a partial pulse.

Each selection step is a two-leg handover switch. The leg that is being left is closed on its own falling edge. The new leg opens only after that close has been seen through a chain of flops clocked on the new clock's falling edge. The output therefore never carries a pulse shorter than half a period of the faster input. If the clock being left has already stopped, the handover can never finish on its own. A force bit then treats the closing step as already done and hands over at once, at the cost of the glitch-free guarantee. Two 16-bit control words drive the block at fixed bit positions. The register access path and the frequency loop lie outside it.

Top module: `sysclk_sel`

## Requirements
- R1: While `rst_n` is low, and afterwards until the enable bit `ctrl_gate[14]` is set, `sysclk` stays low. Every control field resets to 0 in the register file that drives the block.
- R2: The master select bit `ctrl_src[15]` chooses the primary master clock when 0 and the alternate master clock when 1. With the divider at divide-by-1, the invert bit 0, the system select bit 0 and the gate open, `sysclk` follows the chosen pin.
- R3: When the invert bit `ctrl_src[10]` is 1, the chosen master clock is inverted before the second step, so `sysclk` carries its complement.
- R4: The system select bit `ctrl_src[14]` passes the chosen master clock when 0 and the loop clock when 1.
- R5: The pre-divider field `ctrl_src[12:11]` set to 2'b10 halves the clock from the second step, giving a period twice the source period with a 50% duty cycle. 2'b00 passes the clock unchanged. The divide-by-2 flop resets to 0.
- R6: The reserved divider codes 2'b01 and 2'b11 act exactly like 2'b00 (divide by 1).
- R7: When either select bit changes while both the old and the new clocks run, no high or low pulse on `sysclk` is shorter than half a period of the faster of the two clocks, and at no time do both legs of a switch pass their clock at once.
- R8: With the force bit `ctrl_src[13]` at 0, a handover away from a stopped clock does not complete. The output keeps the stopped clock's level and shows no edge.
- R9: With the force bit at 1, a handover completes even though the outgoing clock has stopped. This holds for both the master step and the system step, after which `sysclk` follows the new clock.
- R10: Clearing the enable bit stops `sysclk` low after the pulse in progress has completed, with no shortened pulse, and setting it again restarts the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_pri | input | 1 | Primary master clock pin |
| clk_alt | input | 1 | Alternate master clock pin |
| clk_loop | input | 1 | Frequency loop output clock |
| ctrl_gate | input | 16 | First control word; bit 14 enables the system clock |
| ctrl_src | input | 16 | Second control word; bit 15 master select, 14 system select, 13 force, 12:11 divider, 10 invert |
| sysclk | output | 1 | Gated, divided system clock |

## Verification
The bench builds the block with its default parameters: two falling-edge synchronizer stages in each handover leg and two in the gate. With these values every handover and every gate change settles within a few periods of the slowest input. A 600 ns wait after each control change therefore reaches a steady state, and the behavioural model can be compared on every bench clock. Each input clock has a distinct half period: 10 ns primary, 15 ns alternate, 6 ns loop. A wrong selection, a lost inversion or a missing division then shows up as a level mismatch. The bench can hold any input low at will, which brings the stalled-handover and forced-handover paths of both steps within reach.

// File: rtl/sysclk_sel_pkg.sv
package sysclk_sel_pkg;

   // Width of each control word
   localparam int CTRL_W = 16;

   // Bit positions inside the gate control word
   localparam int ENA_BIT = 14;

   // Bit positions inside the source control word
   localparam int MSEL_BIT  = 15;
   localparam int SSEL_BIT  = 14;
   localparam int FORCE_BIT = 13;
   localparam int DIV_HI    = 12;
   localparam int DIV_LO    = 11;
   localparam int INV_BIT   = 10;

   // Pre-divider codes; the two odd codes are reserved and act as divide-by-1
   typedef enum logic [1:0] {
      PDIV_ONE  = 2'b00,
      PDIV_RSVA = 2'b01,
      PDIV_TWO  = 2'b10,
      PDIV_RSVB = 2'b11
   } prediv_e;

endpackage

// File: rtl/sysclk_sel_sync.sv
// Falling-edge synchronizer chain with asynchronous clear.
module sysclk_sel_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("sysclk_sel_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shreg;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-2:0], d};
   end

   assign q = shreg[STAGES-1];

endmodule

// File: rtl/sysclk_sel_gfmux.sv
// Two-leg handover switch. Leg i passes clk_in[i] when sel == i.
// A leg opens only once the other leg reads closed; each leg's enable moves
// on its own clock's falling edge. force_sw drops the deselected leg at once.
module sysclk_sel_gfmux #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       rst_n,
   input  logic [1:0] clk_in,
   input  logic       sel,
   input  logic       force_sw,
   output logic       clk_out,
   output logic [1:0] leg_on
);

   localparam int LEGS = 2;

   for (genvar i = 0; i < LEGS; i++) begin : g_leg
      logic want;
      logic en_q;

      // Request this leg only while the opposite leg is seen closed
      assign want = (sel == 1'(i)) & ~leg_on[1-i];

      sysclk_sel_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk_in[i]),
         .rst_n (rst_n),
         .d     (want),
         .q     (en_q)
      );

      // Force override: a deselected leg counts as closed immediately
      assign leg_on[i] = en_q & ~(force_sw & (sel != 1'(i)));
   end

   assign clk_out = |(clk_in & leg_on);

endmodule

// File: rtl/sysclk_sel_prediv.sv
// Divide-by-1 / divide-by-2 stage; reserved codes fall back to divide-by-1.
module sysclk_sel_prediv
   import sysclk_sel_pkg::*;
(
   input  logic       rst_n,
   input  logic       clk_src,
   input  logic [1:0] code,
   output logic       clk_out
);

   logic half_q;

   // Known phase after reset: first rising source edge drives the output high
   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) half_q <= 1'b0;
      else        half_q <= ~half_q;
   end

   always_comb begin
      case (prediv_e'(code))
         PDIV_TWO: clk_out = half_q;
         default:  clk_out = clk_src;
      endcase
   end

endmodule

// File: rtl/sysclk_sel_gate.sv
// Output gate; the enable is resampled on falling edges so it only moves
// while the clock is low.
module sysclk_sel_gate #(
   parameter int STAGES = 2
) (
   input  logic rst_n,
   input  logic clk_src,
   input  logic en_async,
   output logic clk_out
);

   logic open_q;

   sysclk_sel_sync #(.STAGES(STAGES)) u_ena_sync (
      .clk   (clk_src),
      .rst_n (rst_n),
      .d     (en_async),
      .q     (open_q)
   );

   assign clk_out = clk_src & open_q;

endmodule

// File: rtl/sysclk_sel.sv
module sysclk_sel
   import sysclk_sel_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int GATE_STAGES = 2
) (
   input  logic              rst_n,
   input  logic              clk_pri,
   input  logic              clk_alt,
   input  logic              clk_loop,
   input  logic [CTRL_W-1:0] ctrl_gate,
   input  logic [CTRL_W-1:0] ctrl_src,
   output logic              sysclk
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sysclk_sel: SYNC_STAGES must be at least 2");
   end
   if (GATE_STAGES < 2) begin : g_bad_gate
      $error("sysclk_sel: GATE_STAGES must be at least 2");
   end
   if (CTRL_W <= MSEL_BIT) begin : g_bad_width
      $error("sysclk_sel: control word too narrow");
   end

   logic       msel, ssel, force_sw, inv, sys_ena;
   logic [1:0] div_code;
   logic       mclk_mux, mclk_pol, sys_src, div_clk;
   logic [1:0] s1_en, s2_en;

   assign msel     = ctrl_src[MSEL_BIT];
   assign ssel     = ctrl_src[SSEL_BIT];
   assign force_sw = ctrl_src[FORCE_BIT];
   assign inv      = ctrl_src[INV_BIT];
   assign div_code = ctrl_src[DIV_HI:DIV_LO];
   assign sys_ena  = ctrl_gate[ENA_BIT];

   logic unused_ctrl;
   assign unused_ctrl = ^{ctrl_gate[CTRL_W-1:ENA_BIT+1], ctrl_gate[ENA_BIT-1:0],
                          ctrl_src[INV_BIT-1:0]};

   // Step 1: master clock choice
   sysclk_sel_gfmux #(.SYNC_STAGES(SYNC_STAGES)) u_mstep (
      .rst_n    (rst_n),
      .clk_in   ({clk_alt, clk_pri}),
      .sel      (msel),
      .force_sw (force_sw),
      .clk_out  (mclk_mux),
      .leg_on   (s1_en)
   );

   // Polarity stage
   assign mclk_pol = mclk_mux ^ inv;

   // Step 2: master clock or loop clock
   sysclk_sel_gfmux #(.SYNC_STAGES(SYNC_STAGES)) u_sstep (
      .rst_n    (rst_n),
      .clk_in   ({clk_loop, mclk_pol}),
      .sel      (ssel),
      .force_sw (force_sw),
      .clk_out  (sys_src),
      .leg_on   (s2_en)
   );

   sysclk_sel_prediv u_prediv (
      .rst_n   (rst_n),
      .clk_src (sys_src),
      .code    (div_code),
      .clk_out (div_clk)
   );

   sysclk_sel_gate #(.STAGES(GATE_STAGES)) u_gate (
      .rst_n    (rst_n),
      .clk_src  (div_clk),
      .en_async (sys_ena),
      .clk_out  (sysclk)
   );

endmodule

// File: rtl/sysclk_sel_chk.sv
module sysclk_sel_chk (
   input logic       rst_n,
   input logic       clk_pri,
   input logic       clk_alt,
   input logic       clk_loop,
   input logic       force_sw,
   input logic [1:0] s1_en,
   input logic [1:0] s2_en,
   input logic       sysclk
);

   // R1: output quiet throughout reset
   a_r1_quiet_in_reset: assert property (@(posedge clk_pri)
      !rst_n |-> !sysclk);

   // R7: master step never passes both pins at once
   a_r7_mstep_exclusive: assert property (@(posedge clk_pri)
      disable iff (!rst_n || force_sw) $onehot0(s1_en));

   // R7: system step never passes both sources at once
   a_r7_sstep_exclusive: assert property (@(posedge clk_loop)
      disable iff (!rst_n || force_sw) $onehot0(s2_en));

   // R8: alternate leg opens only after the primary leg has closed
   a_r8_mstep_order: assert property (@(posedge clk_alt)
      disable iff (!rst_n || force_sw) $rose(s1_en[1]) |-> !s1_en[0]);

   // R8: loop leg opens only after the master leg has closed
   a_r8_sstep_order: assert property (@(posedge clk_loop)
      disable iff (!rst_n || force_sw) $rose(s2_en[1]) |-> !s2_en[0]);

endmodule

bind sysclk_sel sysclk_sel_chk u_chk (
   .rst_n    (rst_n),
   .clk_pri  (clk_pri),
   .clk_alt  (clk_alt),
   .clk_loop (clk_loop),
   .force_sw (ctrl_src[13]),
   .s1_en    (s1_en),
   .s2_en    (s2_en),
   .sysclk   (sysclk)
);

// File: tb/sysclk_sel_test.sv
`timescale 1ns/1ps
module sysclk_sel_test;

   logic tb_clk = 1'b0;
   always #2.5 tb_clk = ~tb_clk;   // 200 MHz sampling clock

   logic rst_n = 1'b0;
   logic pri = 1'b0, alt = 1'b0, lp = 1'b0;
   bit   pri_run = 1'b1, alt_run = 1'b1, lp_run = 1'b1;
   logic [15:0] ctrl_gate = '0;
   logic [15:0] ctrl_src  = '0;
   wire  sysclk;

   always begin #10; if (pri_run) pri = ~pri; end
   always begin #15; if (alt_run) alt = ~alt; end
   always begin #6;  if (lp_run)  lp  = ~lp;  end

   sysclk_sel uut (
      .rst_n     (rst_n),
      .clk_pri   (pri),
      .clk_alt   (alt),
      .clk_loop  (lp),
      .ctrl_gate (ctrl_gate),
      .ctrl_src  (ctrl_src),
      .sysclk    (sysclk)
   );

   int      checks = 0;
   int      errors = 0;
   int      glitches = 0;
   int      edges = 0;
   bit      mon_on = 1'b0;
   bit      have_last = 1'b0;
   realtime last_edge = 0.0;
   realtime min_pulse = 0.0;

   // Pulse-width and edge monitor
   always @(sysclk) begin
      edges++;
      if (mon_on) begin
         if (have_last && (($realtime - last_edge) < min_pulse - 0.01)) glitches++;
         last_edge = $realtime;
         have_last = 1'b1;
      end
   end

   // Behavioural reference level for divide-by-1 settings
   function automatic logic model_level();
      logic src;
      src = ctrl_src[14] ? lp : ((ctrl_src[15] ? alt : pri) ^ ctrl_src[10]);
      return ctrl_gate[14] ? src : 1'b0;
   endfunction

   task automatic check_int(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic compare_window(string req, string what, int ticks);
      int   bad = 0;
      logic fa = 1'b0, fe = 1'b0;
      for (int k = 0; k < ticks; k++) begin
         @(posedge tb_clk);
         if (sysclk !== model_level()) begin
            if (bad == 0) begin fa = sysclk; fe = model_level(); end
            bad++;
         end
      end
      checks++;
      if (bad != 0) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b (%0d mismatching ticks)",
                  req, what, fa, fe, bad);
      end
   endtask

   task automatic switch_check(string req, string what, logic [15:0] nsrc, realtime minp);
      min_pulse = minp;
      have_last = 1'b0;
      glitches  = 0;
      mon_on    = 1'b1;
      ctrl_src  = nsrc;
      #800;
      mon_on = 1'b0;
      check_int(req, {what, " short pulses"}, glitches, 0);
      compare_window(req, {what, " steady"}, 100);
   endtask

   task automatic stop_pri_low();
      @(negedge pri); #1; pri_run = 1'b0;
   endtask

   task automatic stop_lp_low();
      @(negedge lp); #1; lp_run = 1'b0;
   endtask

   initial begin : watchdog
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stimulus
      realtime t0, t1, t2;
      logic [15:0] v;

      // R1: reset and disabled state
      #52.5;
      check_int("R1", "sysclk in reset", int'(sysclk), 0);
      rst_n = 1'b1;
      #600;
      compare_window("R1", "disabled after reset", 100);

      // R2: primary pin selected by default
      ctrl_gate[14] = 1'b1;
      #600;
      compare_window("R2", "primary pin", 100);

      // R7 / R2: move to alternate pin, then back
      v = ctrl_src; v[15] = 1'b1;
      switch_check("R7", "pri->alt", v, 10.0);
      compare_window("R2", "alternate pin", 100);
      v = ctrl_src; v[15] = 1'b0;
      switch_check("R7", "alt->pri", v, 10.0);

      // R3: inversion
      ctrl_src[10] = 1'b1;
      #600;
      compare_window("R3", "inverted primary", 100);
      ctrl_src[10] = 1'b0;
      #600;

      // R4 / R7: loop clock and back
      v = ctrl_src; v[14] = 1'b1;
      switch_check("R7", "master->loop", v, 6.0);
      compare_window("R4", "loop clock", 100);
      v = ctrl_src; v[14] = 1'b0;
      switch_check("R7", "loop->master", v, 6.0);
      compare_window("R4", "master again", 100);

      // R5: divide by two on the primary pin
      ctrl_src[12:11] = 2'b10;
      #600;
      @(posedge sysclk); t0 = $realtime;
      @(negedge sysclk); t1 = $realtime;
      @(posedge sysclk); t2 = $realtime;
      check_int("R5", "div2 high ns", $rtoi(t1 - t0 + 0.5), 20);
      check_int("R5", "div2 period ns", $rtoi(t2 - t0 + 0.5), 40);

      // R6: reserved codes behave as divide-by-1
      ctrl_src[12:11] = 2'b01;
      #600;
      compare_window("R6", "code 01", 100);
      ctrl_src[12:11] = 2'b11;
      #600;
      compare_window("R6", "code 11", 100);
      ctrl_src[12:11] = 2'b00;
      #600;
      compare_window("R5", "code 00", 100);

      // R10: gate off and on with whole pulses
      min_pulse = 10.0; have_last = 1'b0; glitches = 0; mon_on = 1'b1;
      ctrl_gate[14] = 1'b0;
      #600;
      compare_window("R10", "gated off", 100);
      ctrl_gate[14] = 1'b1;
      #600;
      mon_on = 1'b0;
      check_int("R10", "gate short pulses", glitches, 0);
      compare_window("R10", "gated on again", 100);

      // R8: handover stalls when primary has stopped and force is clear
      stop_pri_low();
      #100;
      ctrl_src[15] = 1'b1;
      #5;
      edges = 0;
      #600;
      check_int("R8", "edges during stalled handover", edges, 0);
      check_int("R8", "stalled level", int'(sysclk), 0);

      // R9: force completes master handover
      ctrl_src[13] = 1'b1;
      #600;
      compare_window("R9", "forced to alternate", 100);
      pri_run = 1'b1;
      #600;
      ctrl_src[13] = 1'b0;
      #600;
      compare_window("R9", "alternate after force release", 100);
      v = ctrl_src; v[15] = 1'b0;
      switch_check("R7", "alt->pri after force", v, 10.0);

      // R9: force completes system-step handover away from stopped loop
      v = ctrl_src; v[14] = 1'b1;
      switch_check("R4", "to loop before stop", v, 6.0);
      stop_lp_low();
      #100;
      ctrl_src[14] = 1'b0;
      ctrl_src[13] = 1'b1;
      #600;
      compare_window("R9", "forced loop->master", 100);
      lp_run = 1'b1;
      #600;
      ctrl_src[13] = 1'b0;
      #600;
      compare_window("R9", "master after loop force", 100);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule